// File: doc/BRIEF.md
# Page Half-Swap Repair Engine

This block repairs one 4096-byte page of memory whose contents were laid out for an older value of physical address bit 17. A client hands it the page's base address in the memory port's address space, the present value of bit 17 of the page's physical address, and the bit 17 value that was saved for that page earlier. If the two bit values agree, the page is already correct and the engine finishes at once without any memory traffic.

If they disagree, the engine walks the page as 32 chunks of 128 bytes. In each chunk it exchanges the lower 64 bytes with the upper 64 bytes through a word-wide request/acknowledge memory port, one access outstanding at a time. It uses a local buffer of one half-chunk plus a single holding word. At the end it pulses a completion strobe, together with a strobe saying the page was modified.

Top module: `pswap_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `dirty_o` and `mem_req_o` are all low.
- R2: When `phys_flip_bit_i` equals `saved_bit_i` at the clock edge that accepts `start_i`, the engine issues no memory request. `done_o` is high during the second cycle after that edge, `dirty_o` stays low, and the engine is idle in the cycle after that.
- R3: When the two bits differ, at completion every 128-byte chunk of the page holds its former upper 64 bytes in its lower half and its former lower 64 bytes in its upper half. Memory outside the page is untouched.
- R4: The access order for a differing page goes through chunks 0 to 31 in rising order. Within a chunk it has three phases. First it reads the eight words of the lower half, in rising order. Then, for each word k in rising order, it reads upper word k and writes that value to lower word k. Last, it writes the saved lower word k to upper word k, for k in rising order. A word's byte address is base + 128·chunk + 64·half + 8·k, where half 0 is the lower half and half 1 the upper half. The base must be a multiple of 4096.
- R5: Once `mem_req_o` is raised, `mem_we_o`, `mem_addr_o` and (for writes) `mem_wdata_o` hold steady until the cycle in which `mem_ack_i` is high. A high `mem_ack_i` completes the access at that clock edge, with read data taken from `mem_rdata_i` in the same cycle.
- R6: `done_o` is a single-cycle pulse at the end of every accepted job. `dirty_o` is high only together with `done_o`, and only for a job that swapped the page.
- R7: A `start_i` that arrives while the engine is busy is ignored. The running job keeps its page and its bit comparison, and no second job follows.
- R8: `busy_o` is high from the cycle after the accepting edge up to and including the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job request, accepted only while idle |
| page_base_i | input | ADDR_W | Byte address of the page, 4096-aligned |
| phys_flip_bit_i | input | 1 | Present value of physical address bit 17 |
| saved_bit_i | input | 1 | Bit 17 value saved for this page |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| dirty_o | output | 1 | Page was rewritten, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ack_i |

## Verification
The bench checks an agreeing bit pair with other address bits varied. A design that compared the wrong bit, or the wrong polarity, would either touch memory or leave a stale page. It compares the request stream on every clock against an independently built list of expected accesses, with acknowledge delays of zero to two cycles. A design that wrote the lower half before reading the upper half, or that let the address move before acknowledge, would fail there at once. A stray start during a job, aimed at a second page, would restart the walk or corrupt that page. A second swap of the same page must restore the original image, which catches data taken from the wrong buffer slot.

// File: rtl/pswap_pkg.sv
package pswap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE            = 3'd0,
    ST_CHECK           = 3'd1,
    ST_READ_A          = 3'd2,
    ST_COPY_B_TO_A     = 3'd3,
    ST_WRITE_BUF_TO_B  = 3'd4,
    ST_NEXT_CHUNK      = 3'd5,
    ST_DONE            = 3'd6
  } pswap_state_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } pswap_half_e;

  typedef enum logic {
    WSRC_HOLD = 1'b0,
    WSRC_BUF  = 1'b1
  } pswap_wsrc_e;

endpackage

// File: rtl/pswap_ctr.sv
module pswap_ctr #(
  parameter int unsigned WORDS   = 8,
  parameter int unsigned CHUNKS  = 32,
  parameter int unsigned WORD_W  = 3,
  parameter int unsigned CHUNK_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               word_inc,
  input  logic               chunk_inc,
  output logic [WORD_W-1:0]  word_idx,
  output logic [CHUNK_W-1:0] chunk_idx,
  output logic               word_last,
  output logic               chunk_last
);

  localparam logic [WORD_W-1:0]  WORD_MAX  = WORD_W'(WORDS - 1);
  localparam logic [CHUNK_W-1:0] CHUNK_MAX = CHUNK_W'(CHUNKS - 1);

  logic [WORD_W-1:0]  word_q, word_d;
  logic [CHUNK_W-1:0] chunk_q, chunk_d;
  logic               ctr_en;

  assign word_last  = (word_q == WORD_MAX);
  assign chunk_last = (chunk_q == CHUNK_MAX);
  assign word_idx   = word_q;
  assign chunk_idx  = chunk_q;
  assign ctr_en     = clr | word_inc | chunk_inc;

  always_comb begin
    word_d  = word_q;
    chunk_d = chunk_q;
    if (clr) begin
      word_d  = '0;
      chunk_d = '0;
    end else begin
      if (word_inc) begin
        word_d = word_last ? '0 : word_q + 1'b1;
      end
      if (chunk_inc) begin
        chunk_d = chunk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      chunk_q <= '0;
    end else if (ctr_en) begin
      word_q  <= word_d;
      chunk_q <= chunk_d;
    end
  end

  // R4: a chunk only advances once its word index has wrapped back to zero
  a_r4_chunk_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_inc |-> (word_q == '0));

  // R4: the chunk index never advances past the last chunk
  a_r4_chunk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_inc |-> !chunk_last);

endmodule

// File: rtl/pswap_buf.sv
module pswap_buf #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/pswap_fsm.sv
module pswap_fsm
  import pswap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mismatch_i,
  input  logic         ack_i,
  input  logic         word_last_i,
  input  logic         chunk_last_i,
  output logic         accept_o,
  output logic         word_inc_o,
  output logic         chunk_inc_o,
  output logic         buf_we_o,
  output logic         hold_we_o,
  output logic         req_o,
  output logic         we_o,
  output pswap_half_e  half_o,
  output pswap_wsrc_e  wsrc_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         dirty_o
);

  pswap_state_e state_q, state_d;
  logic         copy_wr_q, copy_wr_d;
  logic         state_en;

  always_comb begin
    state_d     = state_q;
    copy_wr_d   = copy_wr_q;
    accept_o    = 1'b0;
    word_inc_o  = 1'b0;
    chunk_inc_o = 1'b0;
    buf_we_o    = 1'b0;
    hold_we_o   = 1'b0;
    req_o       = 1'b0;
    we_o        = 1'b0;
    half_o      = HALF_LO;
    wsrc_o      = WSRC_BUF;
    done_o      = 1'b0;
    dirty_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        copy_wr_d = 1'b0;
        state_d   = mismatch_i ? ST_READ_A : ST_DONE;
      end
      ST_READ_A: begin
        req_o = 1'b1;
        if (ack_i) begin
          buf_we_o   = 1'b1;
          word_inc_o = 1'b1;
          if (word_last_i) state_d = ST_COPY_B_TO_A;
        end
      end
      ST_COPY_B_TO_A: begin
        req_o = 1'b1;
        if (!copy_wr_q) begin
          half_o = HALF_HI;
          if (ack_i) begin
            hold_we_o = 1'b1;
            copy_wr_d = 1'b1;
          end
        end else begin
          we_o   = 1'b1;
          wsrc_o = WSRC_HOLD;
          if (ack_i) begin
            copy_wr_d  = 1'b0;
            word_inc_o = 1'b1;
            if (word_last_i) state_d = ST_WRITE_BUF_TO_B;
          end
        end
      end
      ST_WRITE_BUF_TO_B: begin
        req_o  = 1'b1;
        we_o   = 1'b1;
        half_o = HALF_HI;
        if (ack_i) begin
          word_inc_o = 1'b1;
          if (word_last_i) state_d = ST_NEXT_CHUNK;
        end
      end
      ST_NEXT_CHUNK: begin
        if (chunk_last_i) begin
          state_d = ST_DONE;
        end else begin
          chunk_inc_o = 1'b1;
          state_d     = ST_READ_A;
        end
      end
      ST_DONE: begin
        done_o  = 1'b1;
        dirty_o = mismatch_i;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign state_en = (state_d != state_q) || (copy_wr_d != copy_wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      copy_wr_q <= 1'b0;
    end else if (state_en) begin
      state_q   <= state_d;
      copy_wr_q <= copy_wr_d;
    end
  end

  // R1: no memory traffic while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_o);

  // R5: an unacknowledged request stays up with the same direction and half
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(we_o) && $stable(half_o)));

  // R6: completion is a one-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: dirty only accompanies done
  a_r6_dirty_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_o |-> done_o);

  // R7: a busy engine never accepts another job
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_o);

endmodule

// File: rtl/pswap_engine.sv
module pswap_engine
  import pswap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int unsigned CHUNK_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] page_base_i,
  input  logic              phys_flip_bit_i,
  input  logic              saved_bit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dirty_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
  localparam int unsigned WORDS_PER_HALF = (CHUNK_BYTES / 2) / BYTES_PER_WORD;
  localparam int unsigned CHUNKS         = PAGE_BYTES / CHUNK_BYTES;
  localparam int unsigned BYTE_W         = $clog2(BYTES_PER_WORD);
  localparam int unsigned WORD_W         = $clog2(WORDS_PER_HALF);
  localparam int unsigned CHUNK_W        = $clog2(CHUNKS);
  localparam int unsigned OFS_W          = CHUNK_W + 1 + WORD_W + BYTE_W;
  localparam int unsigned PAGE_W         = ADDR_W - OFS_W;

  logic [PAGE_W-1:0]  base_q;
  logic               mismatch_q;
  logic [DATA_W-1:0]  hold_q;

  logic               accept;
  logic               word_inc, chunk_inc;
  logic               buf_we, hold_we;
  logic               word_last, chunk_last;
  logic [WORD_W-1:0]  word_idx;
  logic [CHUNK_W-1:0] chunk_idx;
  logic [DATA_W-1:0]  buf_rd;
  pswap_half_e        half_sel;
  pswap_wsrc_e        wsrc_sel;

  pswap_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mismatch_i   (mismatch_q),
    .ack_i        (mem_ack_i),
    .word_last_i  (word_last),
    .chunk_last_i (chunk_last),
    .accept_o     (accept),
    .word_inc_o   (word_inc),
    .chunk_inc_o  (chunk_inc),
    .buf_we_o     (buf_we),
    .hold_we_o    (hold_we),
    .req_o        (mem_req_o),
    .we_o         (mem_we_o),
    .half_o       (half_sel),
    .wsrc_o       (wsrc_sel),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .dirty_o      (dirty_o)
  );

  pswap_ctr #(
    .WORDS   (WORDS_PER_HALF),
    .CHUNKS  (CHUNKS),
    .WORD_W  (WORD_W),
    .CHUNK_W (CHUNK_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .word_inc   (word_inc),
    .chunk_inc  (chunk_inc),
    .word_idx   (word_idx),
    .chunk_idx  (chunk_idx),
    .word_last  (word_last),
    .chunk_last (chunk_last)
  );

  pswap_buf #(
    .DEPTH  (WORDS_PER_HALF),
    .DATA_W (DATA_W),
    .IDX_W  (WORD_W)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (word_idx),
    .wr_data (mem_rdata_i),
    .rd_idx  (word_idx),
    .rd_data (buf_rd)
  );

  // job parameters captured at the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      mismatch_q <= 1'b0;
    end else if (accept) begin
      base_q     <= page_base_i[ADDR_W-1:OFS_W];
      mismatch_q <= phys_flip_bit_i ^ saved_bit_i;
    end
  end

  // single word carried from the upper half to the lower half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_we) begin
      hold_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = {base_q, chunk_idx, half_sel, word_idx, {BYTE_W{1'b0}}};
  assign mem_wdata_o = (wsrc_sel == WSRC_HOLD) ? hold_q : buf_rd;

  // R4: job base must be page aligned
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |-> (page_base_i[OFS_W-1:0] == '0));

  // R5: address and write data hold until acknowledged
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o));

  a_r5_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));

  // R8: requests only appear inside a busy job
  a_r8_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

endmodule

// File: tb/sim_pswap_engine.sv
module sim_pswap_engine;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } acc_t;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] page_base_i;
  logic              phys_flip_bit_i;
  logic              saved_bit_i;
  logic              busy_o, done_o, dirty_o;
  logic              mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o;
  logic              mem_ack_i;
  logic [DATA_W-1:0] mem_rdata_i;

  int n_checks;
  int n_fail;
  int acc_n;
  int wait_cnt;
  bit fast_ack;

  logic [DATA_W-1:0] mem [int unsigned];
  acc_t exp_q[$];

  pswap_engine u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .page_base_i     (page_base_i),
    .phys_flip_bit_i (phys_flip_bit_i),
    .saved_bit_i     (saved_bit_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .dirty_o         (dirty_o),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_ack_i       (mem_ack_i),
    .mem_rdata_i     (mem_rdata_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int unsigned a, input int unsigned seed);
    return {a ^ seed, ~a};
  endfunction

  function automatic logic [DATA_W-1:0] rd_mem(input logic [ADDR_W-1:0] a);
    if (mem.exists(a >> 3)) return mem[a >> 3];
    return '0;
  endfunction

  // memory responder and per-clock reference comparison of the access stream
  always @(negedge clk) begin
    mem_ack_i = 1'b0;
    if (rst_n && mem_req_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "request with none expected", {32'd0, mem_addr_o}, 64'd0);
      end else begin
        chk(exp_q[0].we == mem_we_o && exp_q[0].addr == mem_addr_o,
            "R4/R5", "access address/direction", {31'd0, mem_we_o, mem_addr_o},
            {31'd0, exp_q[0].we, exp_q[0].addr});
        if (mem_we_o)
          chk(exp_q[0].data == mem_wdata_o, "R4/R5", "write data", mem_wdata_o, exp_q[0].data);
      end
      if (wait_cnt == 0) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) mem[mem_addr_o >> 3] = mem_wdata_o;
        else mem_rdata_i = rd_mem(mem_addr_o);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        acc_n++;
        wait_cnt = fast_ack ? 0 : (acc_n % 3);
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic load_page(input logic [ADDR_W-1:0] base, input int unsigned seed);
    for (int w = 0; w < 512; w++) mem[(base >> 3) + w] = pat(base + w * 8, seed);
  endtask

  task automatic build_expect(input logic [ADDR_W-1:0] base);
    exp_q.delete();
    for (int c = 0; c < 32; c++) begin
      logic [ADDR_W-1:0] cb;
      cb = base + c * 128;
      for (int k = 0; k < 8; k++) exp_q.push_back({1'b0, cb + k * 8, 64'd0});
      for (int k = 0; k < 8; k++) begin
        exp_q.push_back({1'b0, cb + 64 + k * 8, 64'd0});
        exp_q.push_back({1'b1, cb + k * 8, rd_mem(cb + 64 + k * 8)});
      end
      for (int k = 0; k < 8; k++) exp_q.push_back({1'b1, cb + 64 + k * 8, rd_mem(cb + k * 8)});
    end
  endtask

  task automatic check_page(input logic [ADDR_W-1:0] base, input int unsigned seed,
                            input bit swapped, input string tag);
    int bad;
    bad = 0;
    for (int o = 0; o < 4096; o += 8) begin
      int src;
      src = swapped ? (o ^ 64) : o;
      if (rd_mem(base + o) != pat(base + src, seed)) begin
        if (bad == 0)
          chk(1'b0, tag, "page word content", rd_mem(base + o), pat(base + src, seed));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, tag, "page content", 0, 0);
  endtask

  task automatic kick(input logic [ADDR_W-1:0] base, input logic cur, input logic saved);
    @(negedge clk);
    page_base_i     = base;
    phys_flip_bit_i = cur;
    saved_bit_i     = saved;
    start_i         = 1'b1;
    @(negedge clk);
    start_i         = 1'b0;
  endtask

  task automatic no_swap_job(input logic [ADDR_W-1:0] base, input logic bitv);
    kick(base, bitv, bitv);
    chk(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
    chk(done_o == 1'b0 && mem_req_o == 1'b0, "R2", "check cycle quiet", {done_o, mem_req_o}, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R2", "done in second cycle", done_o, 1);
    chk(dirty_o == 1'b0, "R2", "no dirty without swap", dirty_o, 0);
    chk(mem_req_o == 1'b0, "R2", "no memory request", mem_req_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R6", "pulse ends, idle", {done_o, busy_o}, 0);
  endtask

  task automatic swap_job(input logic [ADDR_W-1:0] base, input logic cur,
                          input bit stray, input logic [ADDR_W-1:0] stray_base);
    int cyc;
    int dones;
    build_expect(base);
    kick(base, cur, ~cur);
    cyc = 0;
    dones = 0;
    while (cyc < 20000 && !done_o) begin
      chk(busy_o == 1'b1, "R8", "busy during job", busy_o, 1);
      if (stray && cyc == 40) begin
        page_base_i     = stray_base;
        phys_flip_bit_i = cur;
        saved_bit_i     = cur;
        start_i         = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R6", "job completes", done_o, 1);
    chk(dirty_o == 1'b1, "R6", "dirty with swap", dirty_o, 1);
    chk(busy_o == 1'b1, "R8", "busy in done cycle", busy_o, 1);
    chk(exp_q.size() == 0, "R4", "all accesses issued", exp_q.size(), 0);
    if (done_o) dones++;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done_o) dones++;
      if (i == 0) chk(done_o == 1'b0 && dirty_o == 1'b0, "R6", "single pulse", {done_o, dirty_o}, 0);
    end
    chk(dones == 1, "R7", "exactly one completion", dones, 1);
    chk(busy_o == 1'b0 && mem_req_o == 1'b0, "R7", "idle after job", {busy_o, mem_req_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; acc_n = 0; wait_cnt = 0; fast_ack = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; page_base_i = '0;
    phys_flip_bit_i = 1'b0; saved_bit_i = 1'b0;
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", {busy_o, done_o}, 0);
    chk(dirty_o == 1'b0 && mem_req_o == 1'b0, "R1", "quiet after reset", {dirty_o, mem_req_o}, 0);

    // R2: agreeing bits, both polarities
    load_page(32'h0004_3000, 32'h5a5a_0001);
    no_swap_job(32'h0004_3000, 1'b1);
    no_swap_job(32'h0004_3000, 1'b0);
    check_page(32'h0004_3000, 32'h5a5a_0001, 1'b0, "R2");

    // R3/R4/R5: differing bits, delayed acknowledges
    swap_job(32'h0004_3000, 1'b1, 1'b0, 32'h0);
    check_page(32'h0004_3000, 32'h5a5a_0001, 1'b1, "R3");

    // R7: stray start toward another page, immediate acknowledges; swap back
    load_page(32'h0010_0000, 32'h0bad_cafe);
    fast_ack = 1'b1;
    swap_job(32'h0004_3000, 1'b0, 1'b1, 32'h0010_0000);
    check_page(32'h0004_3000, 32'h5a5a_0001, 1'b0, "R3");
    check_page(32'h0010_0000, 32'h0bad_cafe, 1'b0, "R7");

    // neighbouring memory outside the swapped page stays intact
    chk(!mem.exists((32'h0004_3000 - 8) >> 3) && !mem.exists((32'h0004_4000) >> 3),
        "R3", "no access outside page", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule